// File: doc/BRIEF.md
# Forwarding History Register

A single storage register wrapped by ordered read/write port pairs. Within one clock cycle, each read port sees the register's stored value as modified by every enabled write on a lower-numbered port. Several operations that run in one cycle in a fixed order can each see the results of the ones before them, and only the last enabled write is latched at the clock edge. The in-cycle values are discarded at that edge.

The block has two independent port chains, `a` and `b`, that share one storage element. Neither chain forwards to the other. Both chains see the same stored value at their port 0. When both chains write in the same cycle, the `b` chain's result is stored. To use the block as a single-chain register, hold every `b` enable low.

Top module: `ehr_split_reg`

## Requirements
- R1: During reset (`rst_ni` low) the stored value becomes `INIT_VAL`. After reset, with no enables, every read port of both chains returns `INIT_VAL`.
- R2: Read port 0 of each chain returns the stored value. Port 0 of the `a` chain alone behaves as a plain register. Both chains' port-0 reads are always equal.
- R3: In either chain, read port i (i ≥ 1) returns write data i−1 when write enable i−1 is high.
- R4: When write enable i−1 is low, read port i returns read port i−1, and the write data on port i−1 has no effect on any read or on the stored value.
- R5: When only `a` enables are high, the stored value after the clock edge is the write data of the highest-numbered enabled `a` port.
- R6: When no enable in either chain is high, the stored value is unchanged across the clock edge.
- R7: Writes in the `a` chain never appear on `b` reads in the same cycle, and writes in the `b` chain never appear on `a` reads in the same cycle.
- R8: When any `b` enable is high, the stored value after the edge is the write data of the highest-numbered enabled `b` port, whatever the `a` chain writes.
- R9: In the cycle after a write, with no enables, every read port of both chains returns the newly stored value, so no earlier in-cycle value persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_wdata_i | input | NUM_PORTS*DATA_W | Chain a write data, port i at bits [i*DATA_W +: DATA_W] |
| a_wen_i | input | NUM_PORTS | Chain a write enables, bit i for port i |
| a_rdata_o | output | NUM_PORTS*DATA_W | Chain a read data, port i at bits [i*DATA_W +: DATA_W] |
| b_wdata_i | input | NUM_PORTS*DATA_W | Chain b write data, same layout |
| b_wen_i | input | NUM_PORTS | Chain b write enables |
| b_rdata_o | output | NUM_PORTS*DATA_W | Chain b read data, same layout |

## Verification
On every cycle, the assertions check the following:
- Each enabled write is forwarded to the next read port of its own chain.
- A disabled port passes its read through unchanged.
- The two port-0 reads agree.
- The register holds its value when no write is enabled.
- The highest-numbered write of the winning chain is the value stored at the edge.

Three behaviours are shown only by the bench's sweep over every combination of enables in both chains:
- Deeper forwarding, where a read skips past several disabled ports.
- The absence of cross-chain leakage on higher-numbered ports.
- Stale in-cycle values disappearing in the cycle after a write.

// File: rtl/ehr_pkg.sv
package ehr_pkg;
  typedef enum logic [0:0] {
    CHAIN_A = 1'b0,
    CHAIN_B = 1'b1
  } chain_e;

  // Winning chain at the edge: b takes precedence once it writes at all.
  function automatic chain_e pick_chain(input logic b_any);
    return b_any ? CHAIN_B : CHAIN_A;
  endfunction
endpackage

// File: rtl/ehr_fwd_chain.sv
module ehr_fwd_chain #(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned BUS_W    = NUM_PORTS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] base_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [NUM_PORTS-1:0] wen_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [DATA_W-1:0] final_o
);
  logic [DATA_W-1:0] stage [NUM_PORTS+1];

  assign stage[0] = base_i;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_stage
    assign rdata_o[i*DATA_W +: DATA_W] = stage[i];
    assign stage[i+1] = wen_i[i] ? wdata_i[i*DATA_W +: DATA_W] : stage[i];
  end

  assign final_o = stage[NUM_PORTS];

  for (genvar i = 0; i + 1 < NUM_PORTS; i++) begin : g_chk
    p_fwd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wen_i[i] |-> rdata_o[(i+1)*DATA_W +: DATA_W] == wdata_i[i*DATA_W +: DATA_W]);
    p_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wen_i[i] |-> rdata_o[(i+1)*DATA_W +: DATA_W] == rdata_o[i*DATA_W +: DATA_W]);
  end

  p_base_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:0] == base_i);
endmodule

// File: rtl/ehr_merge.sv
module ehr_merge
  import ehr_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned DATA_W    = 32
) (
  input  logic [DATA_W-1:0]    a_final_i,
  input  logic [DATA_W-1:0]    b_final_i,
  input  logic [NUM_PORTS-1:0] b_wen_i,
  output logic [DATA_W-1:0]    next_o
);
  chain_e sel;

  always_comb begin
    sel    = pick_chain(|b_wen_i);
    next_o = (sel == CHAIN_B) ? b_final_i : a_final_i;
  end
endmodule

// File: rtl/ehr_store.sv
module ehr_store #(
  parameter int unsigned DATA_W        = 32,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= INIT_VAL;
    else if (upd_i) q_o <= d_i;
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(q_o));
endmodule

// File: rtl/ehr_split_reg.sv
module ehr_split_reg #(
  parameter int unsigned NUM_PORTS     = 3,
  parameter int unsigned DATA_W        = 32,
  parameter logic [DATA_W-1:0] INIT_VAL = '0,
  localparam int unsigned BUS_W        = NUM_PORTS * DATA_W,
  localparam int unsigned TOP_LO       = (NUM_PORTS - 1) * DATA_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BUS_W-1:0]     a_wdata_i,
  input  logic [NUM_PORTS-1:0] a_wen_i,
  output logic [BUS_W-1:0]     a_rdata_o,
  input  logic [BUS_W-1:0]     b_wdata_i,
  input  logic [NUM_PORTS-1:0] b_wen_i,
  output logic [BUS_W-1:0]     b_rdata_o
);
  logic [DATA_W-1:0] q;
  logic [DATA_W-1:0] a_final;
  logic [DATA_W-1:0] b_final;
  logic [DATA_W-1:0] next_q;
  logic              upd;

  assign upd = (|a_wen_i) | (|b_wen_i);

  ehr_fwd_chain #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_chain_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .base_i (q),
    .wdata_i(a_wdata_i),
    .wen_i  (a_wen_i),
    .rdata_o(a_rdata_o),
    .final_o(a_final)
  );

  ehr_fwd_chain #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_chain_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .base_i (q),
    .wdata_i(b_wdata_i),
    .wen_i  (b_wen_i),
    .rdata_o(b_rdata_o),
    .final_o(b_final)
  );

  ehr_merge #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_merge (
    .a_final_i(a_final),
    .b_final_i(b_final),
    .b_wen_i  (b_wen_i),
    .next_o   (next_q)
  );

  ehr_store #(.DATA_W(DATA_W), .INIT_VAL(INIT_VAL)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (upd),
    .d_i   (next_q),
    .q_o   (q)
  );

  p_share_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rdata_o[DATA_W-1:0] == b_rdata_o[DATA_W-1:0]);
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|a_wen_i) && !(|b_wen_i) |=> $stable(a_rdata_o[DATA_W-1:0]));
  p_a_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_wen_i[NUM_PORTS-1] && !(|b_wen_i) |=>
      a_rdata_o[DATA_W-1:0] == $past(a_wdata_i[TOP_LO +: DATA_W]));
  p_b_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_wen_i[NUM_PORTS-1] |=>
      b_rdata_o[DATA_W-1:0] == $past(b_wdata_i[TOP_LO +: DATA_W]));
endmodule

// File: tb/sim_ehr_split_reg.sv
module sim_ehr_split_reg;
  localparam int NP = 3;
  localparam int DW = 8;
  localparam logic [DW-1:0] INIT = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP*DW-1:0] a_wd = '0, b_wd = '0;
  logic [NP-1:0] a_we = '0, b_we = '0;
  logic [NP*DW-1:0] a_rd, b_rd;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] mq;

  always #10 clk = ~clk;

  ehr_split_reg #(.NUM_PORTS(NP), .DATA_W(DW), .INIT_VAL(INIT)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_wdata_i(a_wd), .a_wen_i(a_we), .a_rdata_o(a_rd),
    .b_wdata_i(b_wd), .b_wen_i(b_we), .b_rdata_o(b_rd)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Expected value of chain read port k given base and chain inputs.
  function automatic logic [DW-1:0] model_rd(input logic [DW-1:0] base,
      input logic [NP*DW-1:0] wd, input logic [NP-1:0] we, input int k);
    logic [DW-1:0] v = base;
    for (int j = 0; j < k; j++) if (we[j]) v = wd[j*DW +: DW];
    return v;
  endfunction

  task automatic check_reads(input string tag);
    for (int k = 0; k < NP; k++) begin
      if (k == 0) begin
        chk({tag, " R2 a0"}, a_rd[0 +: DW], mq);
        chk({tag, " R2 b0"}, b_rd[0 +: DW], mq);
      end else if (a_we[k-1]) begin
        chk({tag, " R3 a"}, a_rd[k*DW +: DW], model_rd(mq, a_wd, a_we, k));
        chk({tag, " R7 b"}, b_rd[k*DW +: DW], model_rd(mq, b_wd, b_we, k));
      end else begin
        chk({tag, " R4 a"}, a_rd[k*DW +: DW], model_rd(mq, a_wd, a_we, k));
        chk({tag, " R7 b"}, b_rd[k*DW +: DW], model_rd(mq, b_wd, b_we, k));
      end
    end
  endtask

  initial begin : watchdog
    #4000000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] nq;
    string tag;
    repeat (3) @(posedge clk);
    #1;
    mq = INIT;
    check_reads("R1");
    @(negedge clk) rst_n = 1'b1;
    #2 check_reads("R1");

    for (int r = 0; r < 4; r++) begin
      for (int e = 0; e < 64; e++) begin
        @(negedge clk);
        a_we = e[2:0];
        b_we = e[5:3];
        for (int i = 0; i < NP; i++) begin
          a_wd[i*DW +: DW] = 8'((e * 7 + i * 37 + r * 91 + 3) & 255);
          b_wd[i*DW +: DW] = 8'((e * 13 + i * 53 + r * 29 + 200) & 255);
        end
        #2 check_reads("sweep");
        if (|b_we) begin
          nq = model_rd(mq, b_wd, b_we, NP); tag = "R8";
        end else if (|a_we) begin
          nq = model_rd(mq, a_wd, a_we, NP); tag = "R5";
        end else begin
          nq = mq; tag = "R6";
        end
        @(posedge clk);
        #1 chk({tag, " stored"}, a_rd[0 +: DW], nq);
        mq = nq;
        // History from the previous cycle must be gone.
        @(negedge clk);
        a_we = '0; b_we = '0;
        #2 for (int k = 0; k < NP; k++) begin
          chk("R9 a", a_rd[k*DW +: DW], mq);
          chk("R9 b", b_rd[k*DW +: DW], mq);
        end
      end
    end

    // A disabled port's data must have no effect.
    @(negedge clk);
    a_we = '0; b_we = '0;
    a_wd = {NP{8'hEE}}; b_wd = {NP{8'h11}};
    #2 check_reads("R4 ignore");
    @(posedge clk);
    #1 chk("R4 stored", a_rd[0 +: DW], mq);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule